// File: doc/BRIEF.md
# Paged per-channel ADC offset adder

This block sits on the receive side behind two ADC streams, I and Q. It adds a small signed correction to each stream and clamps the result to the 10-bit signed sample range. Each channel has its own correction. The correction is in two's complement and counts in units of one LSB of the sample.

Software programs the corrections through a plain write port with address, data and a strobe. Two channels share one offset register. A separate page register decides which channel that offset register writes into. Values written this way are held in a staging copy, and the datapath keeps using the previous values. Only a write of the commit command moves both staged values into the live datapath together, so I and Q change in the same cycle.

Top module: `adc_ofs_pager`

## Requirements
- R1: After reset both offsets are zero, no channel is paged in, and both outputs read 0. Once reset is released, each output equals its input delayed by one cycle until a commit has happened.
- R2: Each output equals the input sample from the previous clock cycle plus that channel's live offset, clamped to the signed 10-bit range.
- R3: A write to address 0x05 with data 0x01 pages in channel I. With data 0x02 it pages in channel Q.
- R4: A write to address 0x10 stores the low 6 bits of the data, read as a two's complement value from -32 to +31, as the staged offset of the paged channel. Bits 7:6 of the data are ignored, so 0xFE means -2 and 0xC5 means +5.
- R5: Staged offsets have no effect on the outputs until a commit.
- R6: A write to address 0xFF with data bit 0 set copies both staged offsets into the live offsets, and the outputs use them from the next cycle on. A write to 0xFF with bit 0 clear does nothing.
- R7: A write to 0x05 with any value other than 0x01 or 0x02, including 0x00, pages out both channels. A later write to 0x10 then changes no offset.
- R8: A sum above +511 gives +511 at the output.
- R9: A sum below -512 gives -512 at the output.
- R10: Writes to any other address change neither the page nor any offset.
- R11: A commit fires once. Offsets staged after a commit stay off the outputs until the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 8 | Configuration register address |
| wr_data | input | 8 | Configuration write data |
| i_in | input | 10 | I channel ADC sample, two's complement |
| q_in | input | 10 | Q channel ADC sample, two's complement |
| i_out | output | 10 | I sample with offset, saturated, registered |
| q_out | output | 10 | Q sample with offset, saturated, registered |

## Verification
The I and Q samples are given different values and offsets of opposite sign, which shows a swapped or merged channel path. Offsets are staged and then held without a commit, which separates the staging copy from the live copy. Writes are then made with the page cleared, with a page value that selects no channel, to unrelated addresses, and with extra high data bits, which shows a bad page decode or a missing mask. Inputs near full scale with the largest positive and negative offsets separate clamping from wrap-around, and a sweep over mid-range inputs is checked against the reference model on every cycle.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

   // Which channel the shared offset register currently targets
   typedef enum logic [1:0] {
      PG_NONE = 2'd0,
      PG_I    = 2'd1,
      PG_Q    = 2'd2
   } page_e;

   localparam int unsigned CH_I = 0;
   localparam int unsigned CH_Q = 1;
   localparam int unsigned N_CH = 2;

   // Turn a byte written to the page register into a page
   function automatic page_e page_decode(input logic [7:0] v);
      page_e p;
      case (v)
         8'h01:   p = PG_I;
         8'h02:   p = PG_Q;
         default: p = PG_NONE;
      endcase
      return p;
   endfunction

   // Channel index paged in by p (only valid when p != PG_NONE)
   function automatic int unsigned page_to_ch(input page_e p);
      return (p == PG_Q) ? CH_Q : CH_I;
   endfunction

endpackage

// File: rtl/ofs_page_reg.sv
module ofs_page_reg
   import ofs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pg_we,
   input  logic [DATA_W-1:0] pg_data,
   output page_e             page,
   output logic [N_CH-1:0]   page_hit
);

   if (DATA_W < 8) begin : g_bad_w
      $error("ofs_page_reg: DATA_W must be at least 8");
   end

   page_e page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         page_q <= PG_NONE;
      else if (pg_we)
         page_q <= page_decode(pg_data[7:0]);
   end

   // One-hot channel select; all zero when nothing is paged in
   for (genvar c = 0; c < N_CH; c++) begin : g_hit
      assign page_hit[c] = (page_q != PG_NONE) && (page_to_ch(page_q) == c);
   end

   assign page = page_q;

endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
   import ofs_pkg::*;
#(
   parameter int OFS_W  = 6,
   parameter int DATA_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        stage_we,
   input  logic [N_CH-1:0]             stage_hit,
   input  logic [DATA_W-1:0]           stage_data,
   input  logic                        commit,
   output logic [N_CH-1:0][OFS_W-1:0]  shadow,
   output logic [N_CH-1:0][OFS_W-1:0]  live
);

   if (OFS_W > DATA_W) begin : g_bad_w
      $error("ofs_bank: OFS_W must not exceed DATA_W");
   end

   logic [N_CH-1:0][OFS_W-1:0] shd_q;
   logic [N_CH-1:0][OFS_W-1:0] act_q;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      // Staging copy: only the paged channel takes the low OFS_W bits
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            shd_q[c] <= '0;
         else if (stage_we && stage_hit[c])
            shd_q[c] <= stage_data[OFS_W-1:0];
      end

      // Live copy: all channels move together on a commit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            act_q[c] <= '0;
         else if (commit)
            act_q[c] <= shd_q[c];
      end
   end

   assign shadow = shd_q;
   assign live   = act_q;

endmodule

// File: rtl/ofs_sat_add.sv
module ofs_sat_add #(
   parameter int SAMPLE_W = 10,
   parameter int OFS_W    = 6,
   parameter bit SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] smp_in,
   input  logic [OFS_W-1:0]    ofs,
   output logic [SAMPLE_W-1:0] smp_out
);

   localparam int SUM_W = SAMPLE_W + 1;
   localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((1 << (SAMPLE_W-1)) - 1);
   localparam logic signed [SUM_W-1:0] MIN_V = -SUM_W'(1 << (SAMPLE_W-1));

   if (OFS_W >= SAMPLE_W) begin : g_bad_w
      $error("ofs_sat_add: OFS_W must be narrower than SAMPLE_W");
   end

   logic signed [SUM_W-1:0]    sum;
   logic        [SAMPLE_W-1:0] res;

   always_comb begin
      sum = $signed({smp_in[SAMPLE_W-1], smp_in})
          + $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});
   end

   if (SATURATE) begin : g_sat
      always_comb begin
         if (sum > MAX_V)
            res = MAX_V[SAMPLE_W-1:0];
         else if (sum < MIN_V)
            res = MIN_V[SAMPLE_W-1:0];
         else
            res = sum[SAMPLE_W-1:0];
      end
   end else begin : g_wrap
      always_comb res = sum[SAMPLE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         smp_out <= '0;
      else
         smp_out <= res;
   end

endmodule

// File: rtl/adc_ofs_pager.sv
module adc_ofs_pager
   import ofs_pkg::*;
#(
   parameter int          SAMPLE_W = 10,
   parameter int          OFS_W    = 6,
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 8,
   parameter logic [7:0]  PAGE_ADR = 8'h05,
   parameter logic [7:0]  OFS_ADR  = 8'h10,
   parameter logic [7:0]  UPD_ADR  = 8'hFF,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [SAMPLE_W-1:0] i_in,
   input  logic [SAMPLE_W-1:0] q_in,
   output logic [SAMPLE_W-1:0] i_out,
   output logic [SAMPLE_W-1:0] q_out
);

   if (ADDR_W < 8) begin : g_bad_a
      $error("adc_ofs_pager: ADDR_W must be at least 8");
   end

   logic                        pg_we, stage_we, commit;
   page_e                       page;
   logic [N_CH-1:0]             page_hit;
   logic [N_CH-1:0][OFS_W-1:0]  shd_ofs;
   logic [N_CH-1:0][OFS_W-1:0]  act_ofs;
   logic [N_CH-1:0][SAMPLE_W-1:0] smp_in, smp_out;

   // Address decode; the commit is a one-cycle strobe, so it clears itself
   assign pg_we    = wr_en && (wr_addr == ADDR_W'(PAGE_ADR));
   assign stage_we = wr_en && (wr_addr == ADDR_W'(OFS_ADR));
   assign commit   = wr_en && (wr_addr == ADDR_W'(UPD_ADR)) && wr_data[0];

   ofs_page_reg #(.DATA_W(DATA_W)) i_page (
      .clk      (clk),
      .rst_n    (rst_n),
      .pg_we    (pg_we),
      .pg_data  (wr_data),
      .page     (page),
      .page_hit (page_hit)
   );

   ofs_bank #(.OFS_W(OFS_W), .DATA_W(DATA_W)) i_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .stage_we   (stage_we),
      .stage_hit  (page_hit),
      .stage_data (wr_data),
      .commit     (commit),
      .shadow     (shd_ofs),
      .live       (act_ofs)
   );

   assign smp_in[CH_I] = i_in;
   assign smp_in[CH_Q] = q_in;

   for (genvar c = 0; c < N_CH; c++) begin : g_path
      ofs_sat_add #(
         .SAMPLE_W (SAMPLE_W),
         .OFS_W    (OFS_W),
         .SATURATE (SATURATE)
      ) i_add (
         .clk     (clk),
         .rst_n   (rst_n),
         .smp_in  (smp_in[c]),
         .ofs     (act_ofs[c]),
         .smp_out (smp_out[c])
      );
   end

   assign i_out = smp_out[CH_I];
   assign q_out = smp_out[CH_Q];

endmodule

// File: rtl/adc_ofs_pager_chk.sv
module adc_ofs_pager_chk
   import ofs_pkg::*;
#(
   parameter int         SAMPLE_W = 10,
   parameter int         OFS_W    = 6,
   parameter int         ADDR_W   = 8,
   parameter int         DATA_W   = 8,
   parameter logic [7:0] PAGE_ADR = 8'h05,
   parameter logic [7:0] OFS_ADR  = 8'h10,
   parameter logic [7:0] UPD_ADR  = 8'hFF
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        wr_en,
   input logic [ADDR_W-1:0]           wr_addr,
   input logic [DATA_W-1:0]           wr_data,
   input page_e                       page,
   input logic [N_CH-1:0][OFS_W-1:0]  shd,
   input logic [N_CH-1:0][OFS_W-1:0]  act,
   input logic [SAMPLE_W-1:0]         i_in,
   input logic [SAMPLE_W-1:0]         q_in,
   input logic [SAMPLE_W-1:0]         i_out,
   input logic [SAMPLE_W-1:0]         q_out
);

   logic upd_go;
   assign upd_go = wr_en && (wr_addr == ADDR_W'(UPD_ADR)) && wr_data[0];

   // R3: a page write of 0x01 or 0x02 selects I or Q
   a_r3_page_i: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(PAGE_ADR) && wr_data == DATA_W'(8'h01)) |=> page == PG_I);
   a_r3_page_q: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(PAGE_ADR) && wr_data == DATA_W'(8'h02)) |=> page == PG_Q);

   // R5 / R11: live offsets move only on a commit
   a_r5_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_go |=> $stable(act));

   // R6: a commit copies the staged values
   a_r6_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
      upd_go |=> act == $past(shd));

   // R7: with nothing paged in, an offset write leaves the staging copy alone
   a_r7_no_page_no_stage: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(OFS_ADR) && page == PG_NONE) |=> $stable(shd));

   // R8: positive sample plus non-negative offset never wraps negative
   a_r8_no_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!i_in[SAMPLE_W-1] && !act[CH_I][OFS_W-1]) |=> !i_out[SAMPLE_W-1]);

   // R9: negative sample plus negative offset never wraps positive
   a_r9_no_neg_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (q_in[SAMPLE_W-1] && act[CH_Q][OFS_W-1]) |=> q_out[SAMPLE_W-1]);

endmodule

bind adc_ofs_pager adc_ofs_pager_chk #(
   .SAMPLE_W (SAMPLE_W),
   .OFS_W    (OFS_W),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .PAGE_ADR (PAGE_ADR),
   .OFS_ADR  (OFS_ADR),
   .UPD_ADR  (UPD_ADR)
) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .page    (page),
   .shd     (shd_ofs),
   .act     (act_ofs),
   .i_in    (i_in),
   .q_in    (q_in),
   .i_out   (i_out),
   .q_out   (q_out)
);

// File: tb/test_adc_ofs_pager.sv
module test_adc_ofs_pager;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [9:0] i_in = '0;
   logic [9:0] q_in = '0;
   logic [9:0] i_out, q_out;

   int checks = 0;
   int failures = 0;
   string cur_req = "R1";

   // Reference model state
   int m_sel = 0;
   int m_shd [2] = '{0, 0};
   int m_act [2] = '{0, 0};
   int exp_i = 0;
   int exp_q = 0;

   always #5 clk = ~clk;

   adc_ofs_pager i_adc_ofs_pager (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .i_in    (i_in),
      .q_in    (q_in),
      .i_out   (i_out),
      .q_out   (q_out)
   );

   function automatic int sat10(input int v);
      if (v > 511)  return 511;
      if (v < -512) return -512;
      return v;
   endfunction

   function automatic int sx6(input logic [7:0] d);
      int u;
      u = int'(d[5:0]);
      return (u >= 32) ? u - 64 : u;
   endfunction

   // Behavioural model, evaluated at each edge from the pre-edge state
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sel = 0; m_shd = '{0, 0}; m_act = '{0, 0};
         exp_i = 0; exp_q = 0;
      end else begin
         exp_i = sat10(int'($signed(i_in)) + m_act[0]);
         exp_q = sat10(int'($signed(q_in)) + m_act[1]);
         if (wr_en) begin
            if (wr_addr == 8'h05)
               m_sel = (wr_data == 8'h01) ? 1 : (wr_data == 8'h02) ? 2 : 0;
            else if (wr_addr == 8'h10 && m_sel != 0)
               m_shd[m_sel-1] = sx6(wr_data);
            else if (wr_addr == 8'hFF && wr_data[0])
               m_act = m_shd;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Compare both outputs with the model (at a falling edge)
   task automatic cmp_model();
      chk({cur_req, " i_out"}, int'($signed(i_out)), exp_i);
      chk({cur_req, " q_out"}, int'($signed(q_out)), exp_q);
   endtask

   task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d,
                       input int iv, input int qv);
      @(negedge clk);
      cmp_model();
      wr_en = we; wr_addr = a; wr_data = d;
      i_in = iv[9:0]; q_in = qv[9:0];
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      step(1'b1, a, d, int'($signed(i_in)), int'($signed(q_in)));
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++)
         step(1'b0, 8'h00, 8'h00, int'($signed(i_in)), int'($signed(q_in)));
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      // R1: reset state
      i_in = 10'd77; q_in = 10'd33;
      repeat (3) @(negedge clk);
      chk("R1 reset i_out", int'($signed(i_out)), 0);
      chk("R1 reset q_out", int'($signed(q_out)), 0);
      rst_n = 1'b1;
      cur_req = "R1";
      step(0, 0, 0, 100, -50);
      idle(2);
      chk("R1 zero offset I", int'($signed(i_out)), 100);
      chk("R1 zero offset Q", int'($signed(q_out)), -50);

      // R3/R4: stage +6 on I, -2 on Q
      cur_req = "R3";
      wr(8'h05, 8'h01);
      cur_req = "R4";
      wr(8'h10, 8'h06);
      cur_req = "R3";
      wr(8'h05, 8'h02);
      cur_req = "R4";
      wr(8'h10, 8'hFE);
      // R5: nothing visible yet
      cur_req = "R5";
      idle(3);
      chk("R5 staged not live I", int'($signed(i_out)), 100);
      chk("R5 staged not live Q", int'($signed(q_out)), -50);
      // R6: commit with bit 0 clear has no effect
      cur_req = "R6";
      wr(8'hFF, 8'hFE);
      idle(2);
      chk("R6 bit0 clear I", int'($signed(i_out)), 100);
      // R6: real commit
      wr(8'hFF, 8'h01);
      idle(2);
      chk("R6 commit I", int'($signed(i_out)), 106);
      chk("R6 commit Q", int'($signed(q_out)), -52);

      // R4: high bits of the data dropped (0xC5 -> +5)
      cur_req = "R4";
      wr(8'h05, 8'h01);
      wr(8'h10, 8'hC5);
      // R11: staged after commit stays off until next commit
      cur_req = "R11";
      idle(3);
      chk("R11 no second commit", int'($signed(i_out)), 106);
      wr(8'hFF, 8'h01);
      idle(2);
      chk("R4 masked data I", int'($signed(i_out)), 105);

      // R7: page cleared / bogus page blocks staging
      cur_req = "R7";
      wr(8'h05, 8'h00);
      wr(8'h10, 8'h1F);
      wr(8'h05, 8'h03);
      wr(8'h10, 8'h1A);
      wr(8'hFF, 8'h01);
      idle(2);
      chk("R7 no page I", int'($signed(i_out)), 105);
      chk("R7 no page Q", int'($signed(q_out)), -52);

      // R10: unrelated addresses ignored
      cur_req = "R10";
      wr(8'h11, 8'h3F);
      wr(8'h06, 8'h02);
      wr(8'h10, 8'h11);
      wr(8'hFF, 8'h01);
      idle(2);
      chk("R10 other addr I", int'($signed(i_out)), 105);
      chk("R10 other addr Q", int'($signed(q_out)), -52);

      // R8/R9: clamp at both ends
      wr(8'h05, 8'h01);
      wr(8'h10, 8'h1F);
      wr(8'h05, 8'h02);
      wr(8'h10, 8'h20);
      wr(8'hFF, 8'h01);
      cur_req = "R8";
      step(0, 0, 0, 500, -500);
      idle(2);
      chk("R8 clamp high I", int'($signed(i_out)), 511);
      cur_req = "R9";
      chk("R9 clamp low Q", int'($signed(q_out)), -512);
      step(0, 0, 0, 511, -512);
      idle(1);
      chk("R8 clamp at max I", int'($signed(i_out)), 511);
      chk("R9 clamp at min Q", int'($signed(q_out)), -512);

      // R2: sweep of inputs against the model
      cur_req = "R2";
      for (int v = -520; v < 520; v += 13)
         step(0, 0, 0, (v < -512) ? -512 : (v > 511 ? 511 : v), -v / 2);
      idle(2);

      finish_run();
   end

endmodule